// File: doc/BRIEF.md
# Coprocessor Bring-up Sequencer

This block sits on the host side of a board and brings an external search coprocessor out of reset. It then configures the coprocessor. All of its timing is counted in cycles of the double-rate clock that the coprocessor also receives. The block waits for a start request while the supplies and clocks are reported good. It then keeps the device reset and the request strobe low for a hold window. Next it releases reset and raises the configuration pin for a fixed window, which latches the device identity.

After that, the block issues one register write in two phases. In the first phase the strobe is high and the write opcode and the configuration-register select are on the buses. In the second phase the strobe is low and the data word sets the handshake-enable bit. Once that bit is set, the coprocessor drives its acknowledge and valid lines back to the host. A parameter can leave the write out. In that case the block finishes as soon as the identity window ends.

The done flag is sticky until local reset. The busy flag covers the time from the accepted start until done.

Top module: `cop_bringup_seq`

## Requirements
- R1: While local reset `rst_n` is low, `dev_rst_n`, `req_strobe`, `cfg_in`, `busy` and `done` are 0, and `cmd_bus` and `req_bus` are all zeros.
- R2: A `start` high is accepted only on a clock edge where `power_good` is also high. Otherwise the block stays idle with `dev_rst_n` low and `busy` low.
- R3: From the cycle after an accepted start, `dev_rst_n` and `req_strobe` are both low for exactly HOLD_CYCLES (default 32) cycles, with `busy` high.
- R4: Next, `dev_rst_n` goes high and stays high. `cfg_in` is high for exactly ID_CYCLES (default 16) cycles.
- R5: Next, `req_strobe` is high for 2 cycles. During those cycles `cmd_bus` is 4'b0100, `req_bus[8:1]` is 8'b0000_0011, and all other `req_bus` bits are 0, so `req_bus` equals 72'h6.
- R6: Next, `req_strobe` is low for 2 cycles. During those cycles `req_bus` has only bit 28 set (72'h1000_0000) and `cmd_bus` is zero.
- R7: `cmd_bus` and `req_bus` are all zeros in every cycle outside the phases of R5 and R6.
- R8: With SKIP_HSK_WRITE=1, `done` rises in the cycle right after the last `cfg_in` cycle, and `req_strobe` never goes high.
- R9: `done` is a sticky level, and a `start` received after done has no effect. `busy` is high from the first hold cycle through the last write cycle, and is never high together with `done`.
- R10: Pulling `rst_n` low in the middle of a sequence at once returns the block to idle with `dev_rst_n` low. A later accepted start runs the full sequence again from the hold phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock that counts every phase |
| rst_n | input | 1 | Asynchronous active-low local reset |
| start | input | 1 | Request to begin bring-up |
| power_good | input | 1 | Supplies and clocks reported stable |
| dev_rst_n | output | 1 | Active-low reset to the coprocessor |
| req_strobe | output | 1 | Request strobe to the coprocessor |
| cfg_in | output | 1 | Device-identity configuration pin |
| cmd_bus | output | 4 | Command bus |
| req_bus | output | REQ_W (72) | Request bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete (sticky) |

## Verification
The bench checks each phase boundary cycle by cycle against a phase table. This catches an off-by-one counter, which would stretch or shorten the hold or identity windows by one cycle. It also catches a write that leaks its opcode or data into a neighbouring cycle. A second instance with the write skipped must show done immediately after the identity window; a design that ignored the parameter would strobe the bus instead. The directed tests cover three more cases. A start without power good must leave the block idle. A start after done must not restart the device, which would pull its reset low again. A mid-sequence local reset must drop the device reset at once and allow a clean full rerun.

// File: rtl/cop_bringup_seq.sv
module cop_bringup_seq #(
  parameter int HOLD_CYCLES    = 32,
  parameter int ID_CYCLES      = 16,
  parameter int REQ_W          = 72,
  parameter bit SKIP_HSK_WRITE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             power_good,
  output logic             dev_rst_n,
  output logic             req_strobe,
  output logic             cfg_in,
  output logic [3:0]       cmd_bus,
  output logic [REQ_W-1:0] req_bus,
  output logic             busy,
  output logic             done
);
  localparam int WR_CYCLES = 2;
  localparam int MAXLEN    = (HOLD_CYCLES > ID_CYCLES) ? HOLD_CYCLES : ID_CYCLES;
  localparam int CW        = $clog2(MAXLEN + 1);
  localparam logic [3:0]       OP_WRITE = 4'b0100;
  localparam logic [REQ_W-1:0] SEL_CFG  = REQ_W'(8'b0000_0011) << 1;
  localparam logic [REQ_W-1:0] HSK_BIT  = REQ_W'(1) << 28;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_ID, S_CMD, S_DATA, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    case (st)
      S_HOLD:  last = CW'(HOLD_CYCLES - 1);
      S_ID:    last = CW'(ID_CYCLES - 1);
      default: last = CW'(WR_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && power_good) begin
          st  <= S_HOLD;
          cnt <= '0;
        end
        S_DONE: ;
        default: if (cnt == last) begin
          cnt <= '0;
          case (st)
            S_HOLD:  st <= S_ID;
            S_ID:    st <= SKIP_HSK_WRITE ? S_DONE : S_CMD;
            S_CMD:   st <= S_DATA;
            default: st <= S_DONE;
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign dev_rst_n  = (st == S_ID) || (st == S_CMD) || (st == S_DATA) || (st == S_DONE);
  assign cfg_in     = (st == S_ID);
  assign req_strobe = (st == S_CMD);
  assign cmd_bus    = (st == S_CMD) ? OP_WRITE : '0;
  assign req_bus    = (st == S_CMD) ? SEL_CFG : (st == S_DATA) ? HSK_BIT : '0;
  assign busy       = (st == S_HOLD) || (st == S_ID) || (st == S_CMD) || (st == S_DATA);
  assign done       = (st == S_DONE);

  a_r3_rst_low_before_id: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_in) |-> $past(!dev_rst_n && !req_strobe));
  a_r4_rst_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst_n |=> dev_rst_n);
  a_r5_strobe_two_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_strobe) |=> req_strobe);
  a_r5_strobe_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && $past(req_strobe)) |=> !req_strobe);
  a_r6_data_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_strobe) |-> (req_bus == HSK_BIT && cmd_bus == '0));
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r9_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  a_r8_skip_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    SKIP_HSK_WRITE |-> !req_strobe);
endmodule

// File: tb/cop_bringup_seq_bench.sv
module cop_bringup_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 81;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, power_good = 1'b0;
  logic dr_a, st_a, cf_a, bz_a, dn_a;
  logic [3:0] cmd_a;
  logic [71:0] req_a;
  logic dr_b, st_b, cf_b, bz_b, dn_b;
  logic [3:0] cmd_b;
  logic [71:0] req_b;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_bringup_seq u_cop_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .power_good(power_good),
    .dev_rst_n(dr_a), .req_strobe(st_a), .cfg_in(cf_a), .cmd_bus(cmd_a),
    .req_bus(req_a), .busy(bz_a), .done(dn_a));

  cop_bringup_seq #(.SKIP_HSK_WRITE(1'b1)) u_skip (
    .clk(clk), .rst_n(rst_n), .start(start), .power_good(power_good),
    .dev_rst_n(dr_b), .req_strobe(st_b), .cfg_in(cf_b), .cmd_bus(cmd_b),
    .req_bus(req_b), .busy(bz_b), .done(dn_b));

  // packing: {dev_rst_n, req_strobe, cfg_in, cmd[3:0], req[71:0], busy, done}
  localparam logic [VW-1:0] V_IDLE = {1'b0, 1'b0, 1'b0, 4'h0, 72'h0, 1'b0, 1'b0};
  localparam logic [VW-1:0] V_HOLD = {1'b0, 1'b0, 1'b0, 4'h0, 72'h0, 1'b1, 1'b0};
  localparam logic [VW-1:0] V_ID   = {1'b1, 1'b0, 1'b1, 4'h0, 72'h0, 1'b1, 1'b0};
  localparam logic [VW-1:0] V_CMD  = {1'b1, 1'b1, 1'b0, 4'h4, 72'h6, 1'b1, 1'b0};
  localparam logic [VW-1:0] V_DATA = {1'b1, 1'b0, 1'b0, 4'h0, 72'h1000_0000, 1'b1, 1'b0};
  localparam logic [VW-1:0] V_DONE = {1'b1, 1'b0, 1'b0, 4'h0, 72'h0, 1'b0, 1'b1};

  // rows: {cycle count, expected vector}
  localparam logic [8+VW-1:0] PHASES [5] = '{
    {8'd32, V_HOLD}, {8'd16, V_ID}, {8'd2, V_CMD}, {8'd2, V_DATA}, {8'd3, V_DONE}};

  function automatic logic [VW-1:0] obs_a();
    return {dr_a, st_a, cf_a, cmd_a, req_a, bz_a, dn_a};
  endfunction
  function automatic logic [VW-1:0] obs_b();
    return {dr_b, st_b, cf_b, cmd_b, req_b, bz_b, dn_b};
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input string tag);
    int row_b;
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < int'(PHASES[r][8+VW-1:VW]); i++) begin
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R3 R4 R5 R6 R7 R9 main"}, obs_a(), PHASES[r][VW-1:0]);
        row_b = r;
        chk({tag, " R8 skip"}, obs_b(), (row_b < 2) ? PHASES[r][VW-1:0] : V_DONE);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset main", obs_a(), V_IDLE);
    chk("R1 reset skip", obs_b(), V_IDLE);
    rst_n = 1'b1;

    start = 1'b1;
    power_good = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 start without power_good", obs_a(), V_IDLE);
    end
    start = 1'b0;
    power_good = 1'b1;
    @(negedge clk);
    chk("R2 power_good alone", obs_a(), V_IDLE);

    start = 1'b1;
    walk("run1");

    start = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 start after done main", obs_a(), V_DONE);
      chk("R9 start after done skip", obs_b(), V_DONE);
    end
    start = 1'b0;

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    start = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      start = 1'b0;
    end
    chk("R10 in id phase before abort", obs_a(), V_ID);
    rst_n = 1'b0;
    #1;
    chk("R10 abort returns idle", obs_a(), V_IDLE);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 stays idle after abort", obs_a(), V_IDLE);
    start = 1'b1;
    walk("R10 rerun");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule